// File: doc/BRIEF.md
# SD Card SPI Command Sequencer

This block sits on the host side of an SD card link in SPI mode. It drives a byte-wide SPI shifter through a one-byte-at-a-time handshake and a chip-select output. After reset it runs the card start-up on its own. First it sends a run of idle bytes with the card deselected. It then issues the reset command, the voltage-check command, the application-command / operating-condition loop and the block-length command. From the answers it derives the card generation, pass or fail, and the select between the slow and fast shift clock.

Every command goes through one transaction engine. The engine lowers chip select and sends a six-byte frame. It then clocks idle bytes until a byte with bit 7 clear arrives, or the poll limit runs out. It may read trailing answer bytes. Last, it raises chip select and sends one more idle byte. Once start-up has succeeded, other logic can issue its own commands through a valid/ready command port and collect each R1 answer through a valid/ready response port. The response is held stable until it is taken, so the consumer may stall it for as long as it likes. A new command is accepted only while the block is idle and no response is waiting.

Top module: `sdspi_cmd_seq`

## Requirements
- R1: After reset, before any command, the block sends PRE_BYTES bytes of 0xFF with spi_cs_n high.
- R2: A command frame is six bytes with spi_cs_n low: {2'b01, index[5:0]}, then argument bits 31:24, 23:16, 15:8, 7:0, then the trailer 0x95.
- R3: The voltage-check step sends 0x48, 0x00, 0x00, 0x01, 0xAA, 0x87 and reads four more bytes, with spi_cs_n low, after its R1 byte.
- R4: After a frame the block sends 0xFF. The first received byte with bit 7 clear is taken as R1, and later bytes are not polled.
- R5: If POLL_LIMIT polled bytes all have bit 7 set, the transaction ends with a timeout and R1 reads as 0xFF.
- R6: After the R1 byte (and any trailing bytes), or after a timeout, spi_cs_n goes high and exactly one more 0xFF byte is sent. spi_cs_n does not change while a byte is in flight.
- R7: The reset command (index 0, argument 0) must answer exactly 0x01. Any other answer, or a timeout, sets init_fail and stops all traffic.
- R8: A voltage-check R1 of 0x01 gives card_ver 2 and a value of 0x05 gives card_ver 1. Any other value sets init_fail. card_ver is 0 until it is known.
- R9: The pair index 55 then index 41 (argument 0) repeats until the index-41 R1 is 0x00. After RETRY_LIMIT failing pairs, init_fail is set.
- R10: Start-up ends with index 16 and argument 512. R1 0x00 sets init_done and fast_clk_sel. Any other value sets init_fail and leaves fast_clk_sel low. last_r1 shows the R1 of the most recent command.
- R11: cmd_ready is high only when init_done is set, no command is running and no response is pending. A request raised during start-up is ignored. busy is high from acceptance until the closing 0xFF byte has completed.
- R12: A user command is framed as in R2. rsp_valid then stays high, with rsp_r1, rsp_timeout and rsp_err stable, until rsp_ready. rsp_err is set when any R1 bit other than bit 0 is set.
- R13: At most one byte is outstanding on the SPI handshake. spi_start is raised again only after spi_done for the previous byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | User command request |
| cmd_ready | output | 1 | Command accepted when high with cmd_valid |
| cmd_index | input | 6 | User command index |
| cmd_arg | input | 32 | User command argument |
| rsp_valid | output | 1 | User response available |
| rsp_ready | input | 1 | Response consumed when high with rsp_valid |
| rsp_r1 | output | 8 | R1 byte of the user command (0xFF on timeout) |
| rsp_timeout | output | 1 | User command got no R1 |
| rsp_err | output | 1 | R1 has an error bit set |
| busy | output | 1 | Start-up or a user command in progress |
| init_done | output | 1 | Start-up succeeded |
| init_fail | output | 1 | Start-up failed |
| card_ver | output | 2 | 0 unknown, 1 first generation, 2 second generation |
| last_r1 | output | 8 | R1 of the most recent command |
| fast_clk_sel | output | 1 | 0 slow start-up clock, 1 fast clock |
| spi_cs_n | output | 1 | Card chip select, active low |
| spi_start | output | 1 | Start one byte exchange |
| spi_tx | output | 8 | Byte to send, valid with spi_start |
| spi_rx | input | 8 | Byte received, valid with spi_done |
| spi_done | input | 1 | Byte exchange finished |

## Verification
The bench goes after the answer-dependent branches. A wrong reset answer, an unknown voltage-check answer and a block-length failure must each stop traffic at once. A design that kept going would put unexpected bytes on the shifter. The operating-condition loop is run both to its retry limit and to a late success. An off-by-one in the retry count would show up as a pair too many or too few. Polling is run to the exact timeout count, and it is also stopped by a byte with bit 7 clear. The trailing voltage-check bytes are zero, so a design that polled them as a new answer would go astray. Stalled responses, a request raised during start-up, and an idle-only R1 (which must not count as an error) cover the port rules.

// File: rtl/sdspi_pkg.sv
package sdspi_pkg;

  localparam int ARG_W       = 32;
  localparam int IDX_W       = 6;
  localparam int FRAME_BYTES = 6;
  localparam int EXTRA_W     = 3;

  localparam logic [7:0]       IDLE_BYTE     = 8'hFF;
  localparam logic [1:0]       FRAME_PREFIX  = 2'b01;
  localparam logic [7:0]       STD_TRAILER   = 8'h95;
  localparam logic [7:0]       VCHK_TRAILER  = 8'h87;
  localparam logic [ARG_W-1:0] VCHK_ARG      = 32'h0000_01AA;
  localparam logic [ARG_W-1:0] BLKLEN_ARG    = 32'd512;
  localparam logic [7:0]       R1_ONLY_IDLE  = 8'h01;
  localparam logic [7:0]       R1_OLD_CARD   = 8'h05;
  localparam logic [EXTRA_W-1:0] VCHK_EXTRA  = 3'd4;

  localparam logic [IDX_W-1:0] IX_RESET  = 6'd0;
  localparam logic [IDX_W-1:0] IX_VCHK   = 6'd8;
  localparam logic [IDX_W-1:0] IX_BLKLEN = 6'd16;
  localparam logic [IDX_W-1:0] IX_OPCOND = 6'd41;
  localparam logic [IDX_W-1:0] IX_APP    = 6'd55;

  typedef enum logic [1:0] {
    VER_NONE = 2'd0,
    VER_ONE  = 2'd1,
    VER_TWO  = 2'd2
  } card_ver_e;

  typedef enum logic [2:0] {
    XS_IDLE, XS_PRE, XS_FRAME, XS_POLL, XS_TAIL, XS_REL
  } xfer_st_e;

  typedef enum logic [3:0] {
    SQ_PRE, SQ_RST, SQ_VCHK, SQ_APP, SQ_OPC, SQ_BLK,
    SQ_READY, SQ_USER, SQ_RESP, SQ_FAIL
  } seq_st_e;

  typedef struct packed {
    logic                 pre;
    logic [IDX_W-1:0]     idx;
    logic [ARG_W-1:0]     arg;
    logic [7:0]           trailer;
    logic [EXTRA_W-1:0]   extra;
  } xfer_req_t;

  typedef struct packed {
    logic [7:0] r1;
    logic       tmo;
  } xfer_res_t;

endpackage

// File: rtl/sdspi_frame_byte.sv
module sdspi_frame_byte
  import sdspi_pkg::*;
(
  input  logic [2:0]       pos,
  input  logic [IDX_W-1:0] idx,
  input  logic [ARG_W-1:0] arg,
  input  logic [7:0]       trailer,
  output logic [7:0]       byte_o
);

  localparam int ARG_BYTES = ARG_W / 8;

  always_comb begin
    byte_o = IDLE_BYTE;
    if (pos == 3'd0) begin
      byte_o = {FRAME_PREFIX, idx};
    end else if (pos == 3'(FRAME_BYTES - 1)) begin
      byte_o = trailer;
    end else begin
      for (int k = 1; k <= ARG_BYTES; k++) begin
        if (pos == 3'(k)) byte_o = arg[8*(ARG_BYTES-k) +: 8];
      end
    end
  end

endmodule

// File: rtl/sdspi_xfer.sv
module sdspi_xfer
  import sdspi_pkg::*;
#(
  parameter int PRE_BYTES  = 16,
  parameter int POLL_LIMIT = 5000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  xfer_req_t  req,
  output logic       done,
  output xfer_res_t  res,
  output logic       spi_cs_n,
  output logic       spi_start,
  output logic [7:0] spi_tx,
  input  logic [7:0] spi_rx,
  input  logic       spi_done
);

  localparam int CNT_MAX = (PRE_BYTES > POLL_LIMIT) ? PRE_BYTES : POLL_LIMIT;
  localparam int CNT_W   = (CNT_MAX < 8) ? 4 : $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] PRE_LAST   = CNT_W'(PRE_BYTES - 1);
  localparam logic [CNT_W-1:0] POLL_LAST  = CNT_W'(POLL_LIMIT - 1);
  localparam logic [CNT_W-1:0] FRAME_LAST = CNT_W'(FRAME_BYTES - 1);

  xfer_st_e         st;
  xfer_req_t        req_q;
  logic             waiting;
  logic [CNT_W-1:0] cnt;
  logic [7:0]       r1_q;
  logic             tmo_q;
  logic [7:0]       frame_b;

  sdspi_frame_byte u_frame (
    .pos     (cnt[2:0]),
    .idx     (req_q.idx),
    .arg     (req_q.arg),
    .trailer (req_q.trailer),
    .byte_o  (frame_b)
  );

  assign spi_start = (st != XS_IDLE) && !waiting;
  assign spi_tx    = (st == XS_FRAME) ? frame_b : IDLE_BYTE;
  assign res       = '{r1: r1_q, tmo: tmo_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= XS_IDLE;
      req_q    <= '0;
      waiting  <= 1'b0;
      cnt      <= '0;
      r1_q     <= IDLE_BYTE;
      tmo_q    <= 1'b0;
      spi_cs_n <= 1'b1;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (st == XS_IDLE) begin
        if (go) begin
          req_q <= req;
          cnt   <= '0;
          tmo_q <= 1'b0;
          r1_q  <= IDLE_BYTE;
          if (req.pre) begin
            spi_cs_n <= 1'b1;
            st       <= XS_PRE;
          end else begin
            spi_cs_n <= 1'b0;
            st       <= XS_FRAME;
          end
        end
      end else if (!waiting) begin
        waiting <= 1'b1;
      end else if (spi_done) begin
        waiting <= 1'b0;
        case (st)
          XS_PRE: begin
            if (cnt == PRE_LAST) begin
              done <= 1'b1;
              st   <= XS_IDLE;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          XS_FRAME: begin
            if (cnt == FRAME_LAST) begin
              cnt <= '0;
              st  <= XS_POLL;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          XS_POLL: begin
            if (!spi_rx[7]) begin
              r1_q <= spi_rx;
              cnt  <= '0;
              if (req_q.extra != '0) begin
                st <= XS_TAIL;
              end else begin
                spi_cs_n <= 1'b1;
                st       <= XS_REL;
              end
            end else if (cnt == POLL_LAST) begin
              tmo_q    <= 1'b1;
              spi_cs_n <= 1'b1;
              st       <= XS_REL;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          XS_TAIL: begin
            if (cnt == CNT_W'(req_q.extra) - CNT_W'(1)) begin
              spi_cs_n <= 1'b1;
              st       <= XS_REL;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: begin
            done <= 1'b1;
            st   <= XS_IDLE;
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/sdspi_init_seq.sv
module sdspi_init_seq
  import sdspi_pkg::*;
#(
  parameter int RETRY_LIMIT = 5000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [IDX_W-1:0] cmd_index,
  input  logic [ARG_W-1:0] cmd_arg,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [7:0]       rsp_r1,
  output logic             rsp_timeout,
  output logic             rsp_err,
  output logic             busy,
  output logic             init_done,
  output logic             init_fail,
  output logic [1:0]       card_ver,
  output logic [7:0]       last_r1,
  output logic             fast_clk_sel,
  output logic             x_go,
  output xfer_req_t        x_req,
  input  logic             x_done,
  input  xfer_res_t        x_res
);

  localparam int TRY_W = (RETRY_LIMIT < 2) ? 1 : $clog2(RETRY_LIMIT);
  localparam logic [TRY_W-1:0] TRY_LAST = TRY_W'(RETRY_LIMIT - 1);

  seq_st_e          st;
  logic             pending;
  logic [TRY_W-1:0] tries;
  logic [IDX_W-1:0] u_idx;
  logic [ARG_W-1:0] u_arg;
  card_ver_e        ver_q;
  logic             launch_st;

  always_comb begin
    launch_st = 1'b0;
    x_req     = '{pre: 1'b0, idx: '0, arg: '0, trailer: STD_TRAILER, extra: '0};
    case (st)
      SQ_PRE:  begin launch_st = 1'b1; x_req.pre = 1'b1; end
      SQ_RST:  begin launch_st = 1'b1; x_req.idx = IX_RESET; end
      SQ_VCHK: begin
        launch_st     = 1'b1;
        x_req.idx     = IX_VCHK;
        x_req.arg     = VCHK_ARG;
        x_req.trailer = VCHK_TRAILER;
        x_req.extra   = VCHK_EXTRA;
      end
      SQ_APP:  begin launch_st = 1'b1; x_req.idx = IX_APP; end
      SQ_OPC:  begin launch_st = 1'b1; x_req.idx = IX_OPCOND; end
      SQ_BLK:  begin launch_st = 1'b1; x_req.idx = IX_BLKLEN; x_req.arg = BLKLEN_ARG; end
      SQ_USER: begin launch_st = 1'b1; x_req.idx = u_idx; x_req.arg = u_arg; end
      default: ;
    endcase
  end

  assign x_go      = launch_st && !pending;
  assign cmd_ready = (st == SQ_READY);
  assign rsp_valid = (st == SQ_RESP);
  assign rsp_err   = |rsp_r1[7:1];
  assign busy      = (st != SQ_READY) && (st != SQ_RESP) && (st != SQ_FAIL);
  assign init_fail = (st == SQ_FAIL);
  assign card_ver  = ver_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= SQ_PRE;
      pending      <= 1'b0;
      tries        <= '0;
      u_idx        <= '0;
      u_arg        <= '0;
      ver_q        <= VER_NONE;
      rsp_r1       <= IDLE_BYTE;
      rsp_timeout  <= 1'b0;
      init_done    <= 1'b0;
      last_r1      <= IDLE_BYTE;
      fast_clk_sel <= 1'b0;
    end else begin
      if (x_go) pending <= 1'b1;
      if (st == SQ_READY && cmd_valid) begin
        u_idx <= cmd_index;
        u_arg <= cmd_arg;
        st    <= SQ_USER;
      end
      if (st == SQ_RESP && rsp_ready) st <= SQ_READY;
      if (x_done) begin
        pending <= 1'b0;
        if (st != SQ_PRE) last_r1 <= x_res.r1;
        case (st)
          SQ_PRE:  st <= SQ_RST;
          SQ_RST:  st <= (x_res.r1 == R1_ONLY_IDLE) ? SQ_VCHK : SQ_FAIL;
          SQ_VCHK: begin
            if (x_res.r1 == R1_ONLY_IDLE) begin
              ver_q <= VER_TWO;
              st    <= SQ_APP;
            end else if (x_res.r1 == R1_OLD_CARD) begin
              ver_q <= VER_ONE;
              st    <= SQ_APP;
            end else begin
              st <= SQ_FAIL;
            end
          end
          SQ_APP:  st <= SQ_OPC;
          SQ_OPC: begin
            if (x_res.r1 == 8'h00) begin
              st <= SQ_BLK;
            end else if (tries == TRY_LAST) begin
              st <= SQ_FAIL;
            end else begin
              tries <= tries + 1'b1;
              st    <= SQ_APP;
            end
          end
          SQ_BLK: begin
            if (x_res.r1 == 8'h00) begin
              init_done    <= 1'b1;
              fast_clk_sel <= 1'b1;
              st           <= SQ_READY;
            end else begin
              st <= SQ_FAIL;
            end
          end
          SQ_USER: begin
            rsp_r1      <= x_res.r1;
            rsp_timeout <= x_res.tmo;
            st          <= SQ_RESP;
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/sdspi_cmd_seq.sv
module sdspi_cmd_seq
  import sdspi_pkg::*;
#(
  parameter int PRE_BYTES   = 16,
  parameter int POLL_LIMIT  = 5000,
  parameter int RETRY_LIMIT = 5000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  output logic        cmd_ready,
  input  logic [5:0]  cmd_index,
  input  logic [31:0] cmd_arg,
  output logic        rsp_valid,
  input  logic        rsp_ready,
  output logic [7:0]  rsp_r1,
  output logic        rsp_timeout,
  output logic        rsp_err,
  output logic        busy,
  output logic        init_done,
  output logic        init_fail,
  output logic [1:0]  card_ver,
  output logic [7:0]  last_r1,
  output logic        fast_clk_sel,
  output logic        spi_cs_n,
  output logic        spi_start,
  output logic [7:0]  spi_tx,
  input  logic [7:0]  spi_rx,
  input  logic        spi_done
);

  logic      x_go;
  logic      x_done;
  xfer_req_t x_req;
  xfer_res_t x_res;

  sdspi_init_seq #(.RETRY_LIMIT(RETRY_LIMIT)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_valid    (cmd_valid),
    .cmd_ready    (cmd_ready),
    .cmd_index    (cmd_index),
    .cmd_arg      (cmd_arg),
    .rsp_valid    (rsp_valid),
    .rsp_ready    (rsp_ready),
    .rsp_r1       (rsp_r1),
    .rsp_timeout  (rsp_timeout),
    .rsp_err      (rsp_err),
    .busy         (busy),
    .init_done    (init_done),
    .init_fail    (init_fail),
    .card_ver     (card_ver),
    .last_r1      (last_r1),
    .fast_clk_sel (fast_clk_sel),
    .x_go         (x_go),
    .x_req        (x_req),
    .x_done       (x_done),
    .x_res        (x_res)
  );

  sdspi_xfer #(.PRE_BYTES(PRE_BYTES), .POLL_LIMIT(POLL_LIMIT)) u_xfer (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (x_go),
    .req       (x_req),
    .done      (x_done),
    .res       (x_res),
    .spi_cs_n  (spi_cs_n),
    .spi_start (spi_start),
    .spi_tx    (spi_tx),
    .spi_rx    (spi_rx),
    .spi_done  (spi_done)
  );

endmodule

// File: rtl/sdspi_cmd_seq_chk.sv
module sdspi_cmd_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_ready,
  input logic       rsp_valid,
  input logic       rsp_ready,
  input logic [7:0] rsp_r1,
  input logic       busy,
  input logic       init_done,
  input logic       init_fail,
  input logic       fast_clk_sel,
  input logic       spi_cs_n,
  input logic       spi_start,
  input logic [7:0] spi_tx,
  input logic       spi_done
);

  logic in_flight;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) in_flight <= 1'b0;
    else if (spi_start) in_flight <= 1'b1;
    else if (spi_done) in_flight <= 1'b0;
  end

  // R13
  one_byte_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(spi_start && in_flight));

  // R6
  cs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_flight && !spi_done) |=> $stable(spi_cs_n));

  // R1
  deselect_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_start && spi_cs_n) |-> (spi_tx == 8'hFF));

  // R10
  fast_after_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fast_clk_sel |-> (init_done && !init_fail));

  // R7
  fail_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_fail |=> (init_fail && !spi_start));

  // R11
  ready_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (!busy && init_done));

  // R12
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_r1)));

endmodule

bind sdspi_cmd_seq sdspi_cmd_seq_chk i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cmd_ready    (cmd_ready),
  .rsp_valid    (rsp_valid),
  .rsp_ready    (rsp_ready),
  .rsp_r1       (rsp_r1),
  .busy         (busy),
  .init_done    (init_done),
  .init_fail    (init_fail),
  .fast_clk_sel (fast_clk_sel),
  .spi_cs_n     (spi_cs_n),
  .spi_start    (spi_start),
  .spi_tx       (spi_tx),
  .spi_done     (spi_done)
);

// File: tb/test_sdspi_cmd_seq.sv
module test_sdspi_cmd_seq;

  localparam int T_PRE   = 16;
  localparam int T_POLL  = 20;
  localparam int T_RETRY = 4;
  localparam int LAT     = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [5:0]  cmd_index = '0;
  logic [31:0] cmd_arg = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [7:0]  rsp_r1;
  logic        rsp_timeout, rsp_err, busy, init_done, init_fail;
  logic [1:0]  card_ver;
  logic [7:0]  last_r1;
  logic        fast_clk_sel, spi_cs_n, spi_start;
  logic [7:0]  spi_tx;
  logic [7:0]  spi_rx = 8'hFF;
  logic        spi_done = 1'b0;

  int nchk = 0;
  int nerr = 0;
  logic [16:0] expq[$];
  bit pend = 0;
  int lat = 0;
  logic [7:0] prx = 8'hFF;
  int cyc = 0;

  always #4 clk = ~clk;

  sdspi_cmd_seq #(.PRE_BYTES(T_PRE), .POLL_LIMIT(T_POLL), .RETRY_LIMIT(T_RETRY))
  i_sdspi_cmd_seq (.*);

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // Byte-level reference model of the card and of the expected host stream.
  always @(negedge clk) begin
    logic [16:0] e;
    cyc++;
    spi_done = 1'b0;
    if (!rst_n) begin
      pend = 0;
    end else if (spi_start) begin
      chk(!pend, "R13 start while byte in flight", 1, 0);
      if (expq.size() == 0) begin
        chk(0, "R1/R7 unexpected byte", {spi_cs_n, spi_tx}, 0);
      end else begin
        e = expq.pop_front();
        chk(spi_cs_n == e[16], "R6 chip select per byte", spi_cs_n, e[16]);
        chk(spi_tx == e[15:8], "R2 transmitted byte", spi_tx, e[15:8]);
        prx = e[7:0];
      end
      pend = 1;
      lat = LAT;
    end else if (pend) begin
      lat--;
      if (lat == 0) begin
        spi_done = 1'b1;
        spi_rx = prx;
        pend = 0;
      end
    end
  end

  initial begin
    #1200000;
    nerr++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    $display("Result: errors=%0d of %0d checks", nerr, nchk + 1);
    $finish;
  end

  task automatic push(input bit cs, input logic [7:0] tx, input logic [7:0] rx);
    expq.push_back({cs, tx, rx});
  endtask

  task automatic q_pre();
    for (int i = 0; i < T_PRE; i++) push(1, 8'hFF, 8'hFF);
  endtask

  task automatic q_frame(input logic [5:0] idx, input logic [31:0] arg, input logic [7:0] crc);
    push(0, {2'b01, idx}, 8'hFF);
    push(0, arg[31:24], 8'hFF);
    push(0, arg[23:16], 8'hFF);
    push(0, arg[15:8], 8'hFF);
    push(0, arg[7:0], 8'hFF);
    push(0, crc, 8'hFF);
  endtask

  task automatic q_cmd(input logic [5:0] idx, input logic [31:0] arg, input logic [7:0] crc,
                       input int npoll, input logic [7:0] r1, input int nextra);
    q_frame(idx, arg, crc);
    for (int i = 0; i < npoll; i++) push(0, 8'hFF, 8'hFF);
    push(0, 8'hFF, r1);
    for (int i = 0; i < nextra; i++) push(0, 8'hFF, 8'h00);
    push(1, 8'hFF, 8'hFF);
  endtask

  task automatic q_tmo(input logic [5:0] idx, input logic [31:0] arg, input logic [7:0] crc);
    q_frame(idx, arg, crc);
    for (int i = 0; i < T_POLL; i++) push(0, 8'hFF, 8'hFF);
    push(1, 8'hFF, 8'hFF);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    expq.delete();
    repeat (3) @(negedge clk);
    chk(spi_cs_n == 1 && spi_start == 0, "R1 reset deselect", {spi_cs_n, spi_start}, 2'b10);
    chk(!init_done && !init_fail && !fast_clk_sel && card_ver == 0, "R10 reset status",
        {init_done, init_fail, fast_clk_sel, card_ver}, 0);
  endtask

  task automatic run_init(input string rq);
    bit bad_ready = 0;
    rst_n = 1'b1;
    for (int i = 0; i < 40000; i++) begin
      @(negedge clk);
      if (cmd_ready && !init_done) bad_ready = 1;
      if (init_done || init_fail) break;
    end
    cmd_valid = 1'b0;
    repeat (30) @(negedge clk);
    chk(expq.size() == 0, rq, expq.size(), 0);
    chk(!bad_ready, "R11 ready during start-up", bad_ready, 0);
  endtask

  task automatic user_cmd(input logic [5:0] idx, input logic [31:0] arg,
                          input logic [7:0] exp_r1, input bit exp_tmo, input bit exp_err);
    logic [7:0] held;
    chk(cmd_ready && !busy, "R11 ready when idle", {cmd_ready, busy}, 2'b10);
    cmd_valid = 1'b1; cmd_index = idx; cmd_arg = arg;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(busy && !cmd_ready, "R11 busy after accept", {busy, cmd_ready}, 2'b10);
    for (int i = 0; i < 5000; i++) begin
      if (rsp_valid) break;
      if (!busy) break;
      @(negedge clk);
    end
    chk(expq.size() == 0, "R11 busy spans closing byte", expq.size(), 0);
    chk(rsp_valid && !busy, "R12 response valid", {rsp_valid, busy}, 2'b10);
    chk(rsp_r1 == exp_r1, "R12 rsp_r1", rsp_r1, exp_r1);
    chk(rsp_timeout == exp_tmo, "R5 rsp_timeout", rsp_timeout, exp_tmo);
    chk(rsp_err == exp_err, "R12 rsp_err", rsp_err, exp_err);
    chk(last_r1 == exp_r1, "R10 last_r1 user", last_r1, exp_r1);
    held = rsp_r1;
    repeat (4) @(negedge clk);
    chk(rsp_valid && rsp_r1 == held && !cmd_ready, "R12 stall holds", {rsp_valid, rsp_r1}, {1'b1, held});
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(!rsp_valid && cmd_ready, "R12 response taken", {rsp_valid, cmd_ready}, 2'b01);
  endtask

  initial begin
    // Second-generation card, one operating-condition retry.
    do_reset();
    q_pre();
    q_cmd(6'd0, 0, 8'h95, 2, 8'h01, 0);
    q_cmd(6'd8, 32'h1AA, 8'h87, 1, 8'h01, 4);
    q_cmd(6'd55, 0, 8'h95, 0, 8'h01, 0);
    q_cmd(6'd41, 0, 8'h95, 3, 8'h01, 0);
    q_cmd(6'd55, 0, 8'h95, 0, 8'h01, 0);
    q_cmd(6'd41, 0, 8'h95, 0, 8'h00, 0);
    q_cmd(6'd16, 512, 8'h95, 1, 8'h00, 0);
    cmd_valid = 1'b1; cmd_index = 6'd5; cmd_arg = 32'h1;
    run_init("R3 R4 R9 full start-up stream");
    chk(init_done && !init_fail, "R10 init_done", {init_done, init_fail}, 2'b10);
    chk(card_ver == 2, "R8 second generation", card_ver, 2);
    chk(fast_clk_sel, "R10 fast clock", fast_clk_sel, 1);
    chk(last_r1 == 8'h00, "R10 last_r1", last_r1, 0);

    q_cmd(6'd17, 32'h1234_5678, 8'h95, 3, 8'h04, 0);
    user_cmd(6'd17, 32'h1234_5678, 8'h04, 0, 1);
    q_tmo(6'd13, 32'hA0B0_C0D0, 8'h95);
    user_cmd(6'd13, 32'hA0B0_C0D0, 8'hFF, 1, 1);
    q_cmd(6'd24, 32'h200, 8'h95, 0, 8'h00, 0);
    user_cmd(6'd24, 32'h200, 8'h00, 0, 0);
    q_cmd(6'd63, 32'hFFFF_FFFF, 8'h95, 5, 8'h01, 0);
    user_cmd(6'd63, 32'hFFFF_FFFF, 8'h01, 0, 0);

    // First-generation card.
    do_reset();
    q_pre();
    q_cmd(6'd0, 0, 8'h95, 0, 8'h01, 0);
    q_cmd(6'd8, 32'h1AA, 8'h87, 0, 8'h05, 4);
    q_cmd(6'd55, 0, 8'h95, 0, 8'h01, 0);
    q_cmd(6'd41, 0, 8'h95, 0, 8'h00, 0);
    q_cmd(6'd16, 512, 8'h95, 0, 8'h00, 0);
    run_init("R8 first generation stream");
    chk(init_done && card_ver == 1, "R8 first generation", card_ver, 1);

    // Reset command answers 0x00.
    do_reset();
    q_pre();
    q_cmd(6'd0, 0, 8'h95, 1, 8'h00, 0);
    run_init("R7 stop after bad reset answer");
    chk(init_fail && !init_done && !fast_clk_sel && !busy && !cmd_ready, "R7 init_fail",
        {init_fail, init_done, fast_clk_sel, busy, cmd_ready}, 5'b10000);

    // Reset command times out.
    do_reset();
    q_pre();
    q_tmo(6'd0, 0, 8'h95);
    run_init("R5 stop after reset timeout");
    chk(init_fail && last_r1 == 8'hFF, "R5 timeout gives 0xFF", last_r1, 8'hFF);

    // Unknown voltage-check answer.
    do_reset();
    q_pre();
    q_cmd(6'd0, 0, 8'h95, 0, 8'h01, 0);
    q_cmd(6'd8, 32'h1AA, 8'h87, 0, 8'h09, 4);
    run_init("R8 stop on unknown version");
    chk(init_fail && card_ver == 0, "R8 unknown version fails", {init_fail, card_ver}, 3'b100);

    // Operating-condition loop exhausts its retries.
    do_reset();
    q_pre();
    q_cmd(6'd0, 0, 8'h95, 0, 8'h01, 0);
    q_cmd(6'd8, 32'h1AA, 8'h87, 0, 8'h01, 4);
    for (int t = 0; t < T_RETRY; t++) begin
      q_cmd(6'd55, 0, 8'h95, 0, 8'h01, 0);
      q_cmd(6'd41, 0, 8'h95, 0, 8'h01, 0);
    end
    run_init("R9 exact retry count");
    chk(init_fail, "R9 retry limit fails", init_fail, 1);

    // Block-length command rejected.
    do_reset();
    q_pre();
    q_cmd(6'd0, 0, 8'h95, 0, 8'h01, 0);
    q_cmd(6'd8, 32'h1AA, 8'h87, 0, 8'h01, 4);
    q_cmd(6'd55, 0, 8'h95, 0, 8'h01, 0);
    q_cmd(6'd41, 0, 8'h95, 0, 8'h00, 0);
    q_cmd(6'd16, 512, 8'h95, 2, 8'h40, 0);
    run_init("R10 stop after block-length reject");
    chk(init_fail && !fast_clk_sel && last_r1 == 8'h40, "R10 block-length failure",
        {init_fail, fast_clk_sel, last_r1}, {2'b10, 8'h40});

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule